// File: doc/BRIEF.md
# Sync Rate Meter

This block times the horizontal and vertical sync streams of a display input against fixed divisions of the 12 MHz system clock. The software can then classify the incoming video mode from two numbers. The horizontal side sums the duration of 64 consecutive line periods in 2 MHz ticks, so the result reads as 128,000,000 / f_h minus one. The vertical side times one frame, from one vertical sync rising edge to the next, in 62.5 kHz ticks, so the result reads as 62,500 / f_v.

Each result sits in a holding register and has a sticky overflow bit. A change flag is raised whenever a newly latched result differs from the one before it, or whenever the new result overflowed. The vertical reference is taken either from a separate vertical sync pin or from a vertical pulse already extracted from composite sync. While the vertical-present input is high, the horizontal result is refreshed only once per frame. While it is low, the horizontal result is refreshed after every 64-line window. A byte-wide read path returns the low byte live. Reading the low byte freezes a copy of the high byte, so a two-byte read stays consistent.

All inputs are synchronous to `clk_i`.

Top module: `sync_rate_meter`

## Requirements
- R1: After a window of L clocks spanning 64 horizontal-sync rising edges, `h_count_o` equals floor((L-1)/HDIV). With a 12 MHz clock and HDIV=6 this is 128e6/f_h - 1.
- R2: After two selected vertical-sync rising edges L clocks apart, `v_count_o` equals floor((L-1)/VDIV)+1. With VDIV=192 this is 62500/f_v.
- R3: While `vpresent_i` is low, the horizontal result is refreshed at the end of every 64-line window.
- R4: While `vpresent_i` is high, the horizontal result is refreshed only at the first window end that follows a rising edge of the selected vertical sync. At all other times it holds.
- R5: With `vsrc_sel_i`=0 the vertical reference is `vsync_sep_i`. With `vsrc_sel_i`=1 it is `vsync_comp_i`. The unselected input has no effect on `v_count_o`.
- R6: If a horizontal window holds more ticks than fit in HW bits, `h_count_o` reads all ones and `h_ovf_o` is 1. The next window that fits clears `h_ovf_o`.
- R7: If a vertical period holds more ticks than fit in VW bits, `v_count_o` reads all ones and `v_ovf_o` is 1.
- R8: `h_chg_o` or `v_chg_o` is set when a latched result differs from the previous one, or when its overflow bit is set. A repeated, in-range result leaves the flag clear.
- R9: Pulsing `clr_h_i` or `clr_v_i` high for one cycle clears the matching flag. A new set in the same cycle takes priority over the clear.
- R10: `h_lo_o` and `v_lo_o` show bits 7:0 of the live result. A one-cycle pulse on `rd_h_lo_i` or `rd_v_lo_i` copies {overflow bit, result bits 14:8 zero-extended} into `h_hi_o` or `v_hi_o`. That copy holds until the next pulse.
- R11: After reset, all counts, overflow bits, flags and byte outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz system clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, positive polarity |
| vsync_sep_i | input | 1 | Separate vertical sync |
| vsync_comp_i | input | 1 | Vertical sync extracted from composite |
| vsrc_sel_i | input | 1 | Vertical reference select (1 = composite) |
| vpresent_i | input | 1 | Vertical sync present indication |
| rd_h_lo_i | input | 1 | Horizontal low-byte read strobe |
| rd_v_lo_i | input | 1 | Vertical low-byte read strobe |
| clr_h_i | input | 1 | Write-1 clear of the horizontal change flag |
| clr_v_i | input | 1 | Write-1 clear of the vertical change flag |
| h_count_o | output | HW | Latched horizontal result |
| h_ovf_o | output | 1 | Horizontal overflow bit |
| v_count_o | output | VW | Latched vertical result |
| v_ovf_o | output | 1 | Vertical overflow bit |
| h_lo_o | output | 8 | Horizontal low byte (live) |
| h_hi_o | output | 8 | Horizontal high byte (snapshot) |
| v_lo_o | output | 8 | Vertical low byte (live) |
| v_hi_o | output | 8 | Vertical high byte (snapshot) |
| h_chg_o | output | 1 | Horizontal change flag |
| v_chg_o | output | 1 | Vertical change flag |

## Verification
The assertions assume that the sync inputs are already synchronous to `clk_i`. They also assume that each sync pulse lasts at least one clock with a low gap after it, so that each rising edge is seen exactly once.

The stimulus drives every sync line and strobe on the falling clock edge, using pulses two clocks wide. It changes a sync period only at pulse boundaries. It waits several whole windows after any change of period or source before sampling, so that the window in which the change happened is never the one checked.

// File: rtl/srm_pkg.sv
package srm_pkg;

  // High byte seen by software: overflow on top, upper result bits below.
  function automatic logic [7:0] hi_byte(input logic ovf, input logic [15:0] val);
    return {ovf, val[14:8]};
  endfunction

  // A latch event raises the change flag on a new value or an overflow.
  function automatic logic change_hit(input logic [15:0] new_val,
                                      input logic [15:0] old_val,
                                      input logic        new_ovf);
    return (new_val != old_val) || new_ovf;
  endfunction

endpackage

// File: rtl/srm_rise.sv
module srm_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/srm_timer.sv
module srm_timer #(
  parameter int DIV   = 6,
  parameter int W     = 14,
  parameter int START = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam int          PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PEND = PW'(DIV - 1);
  localparam logic [W-1:0]  CMAX = '1;

  logic [PW-1:0] pre_q;
  logic          tick;

  assign tick = (pre_q == PEND) && !restart_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (restart_i) begin
      pre_q <= '0;
      cnt_o <= W'(START);
      ovf_o <= 1'b0;
    end else begin
      pre_q <= (pre_q == PEND) ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (cnt_o == CMAX) ovf_o <= 1'b1;
        else               cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srm_result.sv
module srm_result #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  input  logic         ovf_i,
  input  logic         rd_lo_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o,
  output logic         ovf_o,
  output logic [7:0]   lo_o,
  output logic [7:0]   hi_o,
  output logic         chg_o
);
  import srm_pkg::*;

  logic set_w;

  assign set_w = ld_i && change_hit(16'(val_i), 16'(val_o), ovf_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      val_o <= '0;
      ovf_o <= 1'b0;
      hi_o  <= '0;
      chg_o <= 1'b0;
    end else begin
      if (ld_i) begin
        val_o <= val_i;
        ovf_o <= ovf_i;
      end
      if (rd_lo_i) hi_o <= hi_byte(ovf_o, 16'(val_o));
      if (set_w)       chg_o <= 1'b1;
      else if (clr_i)  chg_o <= 1'b0;
    end
  end

  assign lo_o = val_o[7:0];
endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter #(
  parameter int HDIV   = 6,
  parameter int VDIV   = 192,
  parameter int HLINES = 64,
  parameter int HW     = 14,
  parameter int VW     = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          vsync_sep_i,
  input  logic          vsync_comp_i,
  input  logic          vsrc_sel_i,
  input  logic          vpresent_i,
  input  logic          rd_h_lo_i,
  input  logic          rd_v_lo_i,
  input  logic          clr_h_i,
  input  logic          clr_v_i,
  output logic [HW-1:0] h_count_o,
  output logic          h_ovf_o,
  output logic [VW-1:0] v_count_o,
  output logic          v_ovf_o,
  output logic [7:0]    h_lo_o,
  output logic [7:0]    h_hi_o,
  output logic [7:0]    v_lo_o,
  output logic [7:0]    v_hi_o,
  output logic          h_chg_o,
  output logic          v_chg_o
);
  localparam int LW = (HLINES > 1) ? $clog2(HLINES) : 1;
  localparam logic [LW-1:0] LAST_LINE = LW'(HLINES - 1);

  // named internal events
  logic          h_rise_w, v_rise_w, h_bound_w, h_ld_w, v_ld_w, h_pend_w;
  logic          vsel_w;
  logic [HW-1:0] h_run_w;
  logic [VW-1:0] v_run_w;
  logic          h_run_ovf_w, v_run_ovf_w;

  logic [LW-1:0] line_q;
  logic          h_started_q, v_started_q, pend_q;

  assign vsel_w = vsrc_sel_i ? vsync_comp_i : vsync_sep_i;

  srm_rise u_hrise (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(hsync_i), .rise_o(h_rise_w));
  srm_rise u_vrise (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(vsel_w),  .rise_o(v_rise_w));

  assign h_bound_w = h_rise_w && (line_q == '0);
  assign h_pend_w  = pend_q;
  assign h_ld_w    = h_bound_w && h_started_q && (!vpresent_i || pend_q);
  assign v_ld_w    = v_rise_w && v_started_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      line_q      <= '0;
      h_started_q <= 1'b0;
      v_started_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (h_rise_w) line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
      if (h_bound_w) h_started_q <= 1'b1;
      if (v_rise_w)  v_started_q <= 1'b1;
      if (v_rise_w)    pend_q <= 1'b1;
      else if (h_ld_w) pend_q <= 1'b0;
    end
  end

  srm_timer #(.DIV(HDIV), .W(HW), .START(0)) u_htimer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(h_bound_w),
    .cnt_o(h_run_w), .ovf_o(h_run_ovf_w));

  srm_timer #(.DIV(VDIV), .W(VW), .START(1)) u_vtimer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(v_rise_w),
    .cnt_o(v_run_w), .ovf_o(v_run_ovf_w));

  srm_result #(.W(HW)) u_hres (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(h_ld_w), .val_i(h_run_w), .ovf_i(h_run_ovf_w),
    .rd_lo_i(rd_h_lo_i), .clr_i(clr_h_i), .val_o(h_count_o), .ovf_o(h_ovf_o),
    .lo_o(h_lo_o), .hi_o(h_hi_o), .chg_o(h_chg_o));

  srm_result #(.W(VW)) u_vres (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(v_ld_w), .val_i(v_run_w), .ovf_i(v_run_ovf_w),
    .rd_lo_i(rd_v_lo_i), .clr_i(clr_v_i), .val_o(v_count_o), .ovf_o(v_ovf_o),
    .lo_o(v_lo_o), .hi_o(v_hi_o), .chg_o(v_chg_o));
endmodule

// File: rtl/srm_chk.sv
module srm_chk #(
  parameter int HW = 14,
  parameter int VW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vpresent_i,
  input logic          rd_h_lo_i,
  input logic          clr_h_i,
  input logic [HW-1:0] h_count_o,
  input logic          h_ovf_o,
  input logic [VW-1:0] v_count_o,
  input logic          v_ovf_o,
  input logic [7:0]    h_hi_o,
  input logic          h_chg_o,
  input logic          h_ld_w,
  input logic          v_ld_w,
  input logic          h_pend_w
);
  // R6
  h_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ovf_o |-> (h_count_o == {HW{1'b1}}));
  // R7
  v_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_ovf_o |-> (v_count_o == {VW{1'b1}}));
  // R3
  h_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(h_count_o) |-> $past(h_ld_w));
  // R2
  v_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(v_count_o) |-> $past(v_ld_w));
  // R4
  h_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_ld_w && vpresent_i) |-> h_pend_w);
  // R8
  h_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(h_chg_o) |-> $past(h_ld_w));
  // R9
  h_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_h_i && !h_ld_w) |=> !h_chg_o);
  // R10
  hi_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_h_lo_i |=> $stable(h_hi_o));
endmodule

bind sync_rate_meter srm_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vpresent_i(vpresent_i), .rd_h_lo_i(rd_h_lo_i),
  .clr_h_i(clr_h_i), .h_count_o(h_count_o), .h_ovf_o(h_ovf_o), .v_count_o(v_count_o),
  .v_ovf_o(v_ovf_o), .h_hi_o(h_hi_o), .h_chg_o(h_chg_o), .h_ld_w(h_ld_w),
  .v_ld_w(v_ld_w), .h_pend_w(h_pend_w));

// File: tb/sync_rate_meter_test.sv
module sync_rate_meter_test;
  localparam int CLK_PERIOD = 10;
  localparam int HDIV = 6, VDIV = 48, LINES = 64, HW = 10, VW = 8;
  localparam int HMAX = (1 << HW) - 1, VMAX = (1 << VW) - 1;

  logic clk = 0, rst_n = 0;
  logic hsync = 0, vs_sep = 0, vs_comp = 0, vsel = 0, vpres = 0;
  logic rd_h = 0, rd_v = 0, clr_h = 0, clr_v = 0;
  logic [HW-1:0] h_count; logic h_ovf;
  logic [VW-1:0] v_count; logic v_ovf;
  logic [7:0] h_lo, h_hi, v_lo, v_hi;
  logic h_chg, v_chg;

  int total = 0, bad = 0;
  int hper = 30, vper_sep = 1920, vper_comp = 3840;
  logic hen = 0, ven_sep = 0, ven_comp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_rate_meter #(.HDIV(HDIV), .VDIV(VDIV), .HLINES(LINES), .HW(HW), .VW(VW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_sep_i(vs_sep),
    .vsync_comp_i(vs_comp), .vsrc_sel_i(vsel), .vpresent_i(vpres),
    .rd_h_lo_i(rd_h), .rd_v_lo_i(rd_v), .clr_h_i(clr_h), .clr_v_i(clr_v),
    .h_count_o(h_count), .h_ovf_o(h_ovf), .v_count_o(v_count), .v_ovf_o(v_ovf),
    .h_lo_o(h_lo), .h_hi_o(h_hi), .v_lo_o(v_lo), .v_hi_o(v_hi),
    .h_chg_o(h_chg), .v_chg_o(v_chg));

  // sync generators: 2-clock pulses, period in clocks
  initial forever begin
    if (hen) begin
      hsync = 1; repeat (2) @(negedge clk);
      hsync = 0; repeat (hper - 2) @(negedge clk);
    end else @(negedge clk);
  end
  initial forever begin
    if (ven_sep) begin
      vs_sep = 1; repeat (2) @(negedge clk);
      vs_sep = 0;
      for (int i = 0; i < vper_sep - 2; i++) begin
        if (!ven_sep) break;
        @(negedge clk);
      end
    end else @(negedge clk);
  end
  initial forever begin
    if (ven_comp) begin
      vs_comp = 1; repeat (2) @(negedge clk);
      vs_comp = 0; repeat (vper_comp - 2) @(negedge clk);
    end else @(negedge clk);
  end

  function automatic int exp_h(int p);
    int t = (LINES * p - 1) / HDIV;
    return (t > HMAX) ? HMAX : t;
  endfunction
  function automatic int exp_v(int q);
    int t = (q - 1) / VDIV + 1;
    return (t > VMAX) ? VMAX : t;
  endfunction
  function automatic int hib(int ovf, int val);
    return (ovf << 7) | ((val >> 8) & 8'h7f);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R11 h_count", int'(h_count), 0);
    chk("R11 v_count", int'(v_count), 0);
    chk("R11 flags", int'({h_chg, v_chg, h_ovf, v_ovf}), 0);
    chk("R11 bytes", int'({h_lo, h_hi, v_lo, v_hi}), 0);
  endtask

  task automatic t_h_basic;
    hper = 30; hen = 1;
    repeat (4 * LINES * 30) @(negedge clk);
    chk("R1 h_count p30", int'(h_count), exp_h(30));
    chk("R6 h_ovf clear", int'(h_ovf), 0);
    chk("R8 h_chg on new value", int'(h_chg), 1);
  endtask

  task automatic t_flag_clear;
    pulse(clr_h);
    @(negedge clk);
    chk("R9 h_chg cleared", int'(h_chg), 0);
    repeat (3 * LINES * 30) @(negedge clk);
    chk("R3 h_count refreshed same", int'(h_count), exp_h(30));
    chk("R8 h_chg stays clear on repeat", int'(h_chg), 0);
  endtask

  task automatic t_snapshot;
    pulse(rd_h);
    @(negedge clk);
    chk("R10 h_lo live", int'(h_lo), exp_h(30) & 8'hff);
    chk("R10 h_hi snap", int'(h_hi), hib(0, exp_h(30)));
    hper = 24;
    repeat (4 * LINES * 30) @(negedge clk);
    chk("R3 h_count p24", int'(h_count), exp_h(24));
    chk("R10 h_hi held", int'(h_hi), hib(0, exp_h(30)));
    pulse(rd_h);
    @(negedge clk);
    chk("R10 h_hi resnap", int'(h_hi), hib(0, exp_h(24)));
  endtask

  task automatic t_h_ovf;
    hper = 100;
    repeat (3 * LINES * 100) @(negedge clk);
    chk("R6 h_count sat", int'(h_count), HMAX);
    chk("R6 h_ovf set", int'(h_ovf), 1);
    chk("R8 h_chg on ovf", int'(h_chg), 1);
    pulse(rd_h);
    @(negedge clk);
    chk("R10 h_hi ovf bit", int'(h_hi), hib(1, HMAX));
    hper = 30;
    repeat (3 * LINES * 100) @(negedge clk);
    chk("R6 h_ovf released", int'(h_ovf), 0);
    chk("R1 h_count back", int'(h_count), exp_h(30));
  endtask

  task automatic t_v_sep;
    vsel = 0; vper_sep = 1920; ven_sep = 1;
    vper_comp = 3840; ven_comp = 1;
    repeat (4 * 3840) @(negedge clk);
    chk("R2 v_count sep", int'(v_count), exp_v(1920));
    chk("R5 comp ignored", int'(v_count), exp_v(1920));
    chk("R8 v_chg set", int'(v_chg), 1);
    pulse(clr_v);
    @(negedge clk);
    chk("R9 v_chg cleared", int'(v_chg), 0);
  endtask

  task automatic t_v_sel;
    vsel = 1;
    repeat (4 * 3840) @(negedge clk);
    chk("R5 v_count comp", int'(v_count), exp_v(3840));
    chk("R10 v_lo live", int'(v_lo), exp_v(3840) & 8'hff);
  endtask

  task automatic t_v_ovf;
    ven_comp = 0; vsel = 0; vper_sep = 13000;
    repeat (3 * 13000 + 100) @(negedge clk);
    chk("R7 v_count sat", int'(v_count), VMAX);
    chk("R7 v_ovf set", int'(v_ovf), 1);
    pulse(rd_v);
    @(negedge clk);
    chk("R10 v_hi ovf", int'(v_hi), hib(1, VMAX));
  endtask

  task automatic t_h_vpresent;
    ven_sep = 0; vpres = 1; hper = 30;
    repeat (3 * LINES * 30) @(negedge clk);
    chk("R4 start p30", int'(h_count), exp_h(30));
    hper = 24;
    repeat (4 * LINES * 24) @(negedge clk);
    chk("R4 held without vsync", int'(h_count), exp_h(30));
    @(negedge clk); ven_sep = 1;
    repeat (3) @(negedge clk); ven_sep = 0;
    repeat (3 * LINES * 24) @(negedge clk);
    chk("R4 updated after vsync", int'(h_count), exp_h(24));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_h_basic();
    t_flag_clear();
    t_snapshot();
    t_h_ovf();
    t_v_sep();
    t_v_sel();
    t_v_ovf();
    t_h_vpresent();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule